// File: doc/BRIEF.md
# Multicycle Pipeline Issue Interlock

This block decides, cycle by cycle, whether the instruction waiting in decode of an in-order pipeline may issue or must stall. The pipeline's execute phase has a depth chosen by the instruction class. Floating-point arithmetic takes four execute stages, loads and stores take two, and integer arithmetic takes one. Every unit is fully pipelined, so one instruction can issue in any cycle in which no dependence holds it back.

For each architectural register, the interlock keeps a countdown of the cycles left before a pending result can be forwarded. Integer and floating-point registers are tracked in two separate spaces. Both source operands of the decode instruction are compared against these countdowns every cycle. A store reads its data operand one cycle after its other operands, so it tolerates one more cycle of pending result on that operand. The interlock also enforces the single delay cycle after every branch. In that cycle only an instruction marked as filling the delay slot may issue. Otherwise the cycle is lost as a bubble.

The outputs are the issue and stall decisions, a flag for the branch bubble, and a free-running cycle number. A testbench uses the cycle number to log at which cycle each instruction issued. Functional units, the register file and memory lie outside the block.

Top module: `mc_issue_gate`

## Requirements
- R1: After reset the cycle number is 0, issue and stall are low while no instruction is presented, and no register is marked pending, so a first instruction issues in the cycle it is presented.
- R2: The class code on dec_kind is 0 integer arithmetic, 1 load, 2 store, 3 floating-point arithmetic and 4 branch. An instruction with no pending dependence issues in the cycle it is presented, allowing back-to-back issue every cycle. Issue and stall are never high together, and stall is high exactly when an instruction is presented and does not issue.
- R3: A consumer of a load result (other than as store data) issues no earlier than 2 cycles after the load, which is one stall cycle when it follows directly.
- R4: A consumer of a floating-point result (other than as store data) issues no earlier than 4 cycles after the producer, which is three stall cycles when it follows directly.
- R5: A consumer of an integer result issues in the cycle right after the producer, with no stall.
- R6: The B source of a store (code 2) is its data operand and needs one cycle less of separation: load to store data gives no stall, and floating-point to store data gives two stalls. A store's A source (address) follows R3 to R5 unchanged.
- R7: A source marks the floating-point space with its fp bit set to 1 and the integer space with 0. A dependence exists only when both the space and the index match.
- R8: Pending countdowns keep running while decode is stalled or empty. After a floating-point producer followed by 2 idle cycles, a consumer presented in the third cycle after it stalls for only one cycle.
- R9: In the cycle after a branch issues, only an instruction with dec_in_slot=1 may issue. Any other instruction stalls, and slot_bubble is high in that cycle unless something issues.
- R10: The cycle number increases by one on every clock after reset.
- R11: A six-instruction loop (load, floating-point add, store, integer subtract, integer add, branch) takes 10 cycles per iteration in program order. It takes 7 cycles when the store is moved into the branch delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_kind | input | 3 | Class code of the decode instruction (see R2) |
| dec_in_slot | input | 1 | Instruction was placed in a branch delay slot |
| src_a_en | input | 1 | Source A is used |
| src_a_fp | input | 1 | Source A register space, 1 = floating point |
| src_a_idx | input | REG_W | Source A register index |
| src_b_en | input | 1 | Source B is used (store data for a store) |
| src_b_fp | input | 1 | Source B register space |
| src_b_idx | input | REG_W | Source B register index |
| dst_en | input | 1 | Instruction writes a destination |
| dst_fp | input | 1 | Destination register space |
| dst_idx | input | REG_W | Destination register index |
| issue | output | 1 | Decode instruction issues this cycle |
| stall | output | 1 | Decode instruction is held this cycle |
| slot_bubble | output | 1 | Branch delay cycle lost with no issue |
| cycle | output | CYC_W | Cycles since reset |

## Verification
A countdown left at a wrong value shows at the ports in the very cycle that a dependent instruction is presented. Either issue rises one or more cycles too early, or stall persists past the expected issue cycle, so an error in a load, floating-point or store-data latency changes the logged issue cycle of the consumer. A lost or stuck branch-slot flag shows in the cycle after the branch as a missing bubble or an extra stall. The loop scenarios catch accumulated errors as a wrong cycle count per iteration.

// File: rtl/mcig_pkg.sv
package mcig_pkg;
   typedef enum logic [2:0] {
      K_INT    = 3'd0,
      K_LOAD   = 3'd1,
      K_STORE  = 3'd2,
      K_FP     = 3'd3,
      K_BRANCH = 3'd4
   } kind_e;

   localparam int unsigned N_SPACE = 2;

   // execute depth of a class; unknown codes behave as integer
   function automatic int unsigned kind_depth(input logic [2:0] k,
                                              input int unsigned d_int,
                                              input int unsigned d_mem,
                                              input int unsigned d_fp);
      case (k)
         K_LOAD, K_STORE: kind_depth = d_mem;
         K_FP:            kind_depth = d_fp;
         default:         kind_depth = d_int;
      endcase
   endfunction
endpackage

// File: rtl/mcig_regtrack.sv
module mcig_regtrack #(
   parameter int unsigned REG_W = 5,
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_idx,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic [REG_W-1:0] rd_idx_a,
   input  logic [REG_W-1:0] rd_idx_b,
   output logic [CNT_W-1:0] rd_cnt_a,
   output logic [CNT_W-1:0] rd_cnt_b
);
   localparam int unsigned NREG = 1 << REG_W;

   logic [CNT_W-1:0] cnt_q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q[i] <= '0;
         end else if (wr_en && (wr_idx == REG_W'(i))) begin
            cnt_q[i] <= wr_cnt;
         end else if (cnt_q[i] != '0) begin
            cnt_q[i] <= cnt_q[i] - CNT_W'(1);
         end
      end
   end

   assign rd_cnt_a = cnt_q[rd_idx_a];
   assign rd_cnt_b = cnt_q[rd_idx_b];
endmodule

// File: rtl/mcig_hazard.sv
module mcig_hazard #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             a_en,
   input  logic [CNT_W-1:0] a_cnt,
   input  logic             b_en,
   input  logic [CNT_W-1:0] b_cnt,
   input  logic             b_late,
   output logic             blocked
);
   logic [CNT_W-1:0] b_allow;
   logic             a_block;
   logic             b_block;

   // a late-consumed operand tolerates one remaining cycle
   assign b_allow = b_late ? CNT_W'(1) : '0;
   assign a_block = a_en && (a_cnt != '0);
   assign b_block = b_en && (b_cnt > b_allow);
   assign blocked = a_block || b_block;
endmodule

// File: rtl/mcig_slot.sv
module mcig_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic branch_issued,
   output logic in_delay
);
   always_ff @(posedge clk) begin
      if (!rst_n) in_delay <= 1'b0;
      else        in_delay <= branch_issued;
   end
endmodule

// File: rtl/mc_issue_gate.sv
module mc_issue_gate
   import mcig_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter int unsigned DEPTH_INT = 1,
   parameter int unsigned DEPTH_MEM = 2,
   parameter int unsigned DEPTH_FP  = 4,
   parameter int unsigned CYC_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [2:0]       dec_kind,
   input  logic             dec_in_slot,
   input  logic             src_a_en,
   input  logic             src_a_fp,
   input  logic [REG_W-1:0] src_a_idx,
   input  logic             src_b_en,
   input  logic             src_b_fp,
   input  logic [REG_W-1:0] src_b_idx,
   input  logic             dst_en,
   input  logic             dst_fp,
   input  logic [REG_W-1:0] dst_idx,
   output logic             issue,
   output logic             stall,
   output logic             slot_bubble,
   output logic [CYC_W-1:0] cycle
);
   localparam int unsigned MAX_MI = (DEPTH_MEM > DEPTH_INT) ? DEPTH_MEM : DEPTH_INT;
   localparam int unsigned MAX_D  = (DEPTH_FP > MAX_MI) ? DEPTH_FP : MAX_MI;
   localparam int unsigned CNT_W  = $clog2(MAX_D) + 1;

   if (DEPTH_INT < 1 || DEPTH_MEM < 1 || DEPTH_FP < 1) begin : g_bad_depth
      $error("mc_issue_gate: every execute depth must be at least 1");
   end
   if (REG_W < 1 || REG_W > 8) begin : g_bad_regw
      $error("mc_issue_gate: REG_W out of range 1..8");
   end
   if (CYC_W < 2) begin : g_bad_cycw
      $error("mc_issue_gate: CYC_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_a [N_SPACE];
   logic [CNT_W-1:0] cnt_b [N_SPACE];
   logic [CNT_W-1:0] load_cnt;
   logic             blocked;
   logic             in_delay;
   logic             slot_deny;
   logic             is_store;
   logic             is_branch;
   logic [CYC_W-1:0] cycle_q;

   assign is_store  = (dec_kind == K_STORE);
   assign is_branch = (dec_kind == K_BRANCH);
   assign load_cnt  = CNT_W'(kind_depth(dec_kind, DEPTH_INT, DEPTH_MEM, DEPTH_FP) - 1);

   for (genvar s = 0; s < N_SPACE; s++) begin : g_space
      mcig_regtrack #(.REG_W(REG_W), .CNT_W(CNT_W)) u_track (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (issue && dst_en && (dst_fp == s[0])),
         .wr_idx   (dst_idx),
         .wr_cnt   (load_cnt),
         .rd_idx_a (src_a_idx),
         .rd_idx_b (src_b_idx),
         .rd_cnt_a (cnt_a[s]),
         .rd_cnt_b (cnt_b[s])
      );
   end

   mcig_hazard #(.CNT_W(CNT_W)) u_hazard (
      .a_en    (src_a_en),
      .a_cnt   (cnt_a[src_a_fp]),
      .b_en    (src_b_en),
      .b_cnt   (cnt_b[src_b_fp]),
      .b_late  (is_store),
      .blocked (blocked)
   );

   mcig_slot u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .branch_issued (issue && is_branch),
      .in_delay      (in_delay)
   );

   assign slot_deny   = in_delay && !dec_in_slot;
   assign issue       = dec_valid && !blocked && !slot_deny;
   assign stall       = dec_valid && !issue;
   assign slot_bubble = in_delay && !issue;

   always_ff @(posedge clk) begin
      if (!rst_n) cycle_q <= '0;
      else        cycle_q <= cycle_q + CYC_W'(1);
   end
   assign cycle = cycle_q;
endmodule

// File: rtl/mcig_gate_chk.sv
module mcig_gate_chk #(
   parameter int unsigned REG_W = 5,
   parameter int unsigned CYC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dec_valid,
   input logic [2:0]       dec_kind,
   input logic             dec_in_slot,
   input logic             src_a_en,
   input logic             src_a_fp,
   input logic [REG_W-1:0] src_a_idx,
   input logic             dst_en,
   input logic             dst_fp,
   input logic [REG_W-1:0] dst_idx,
   input logic             issue,
   input logic             stall,
   input logic             slot_bubble,
   input logic [CYC_W-1:0] cycle
);
   a_r2_issue_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue && stall));

   a_r2_issue_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (issue || stall) |-> dec_valid);

   a_r3_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && dec_kind == 3'd1 && dst_en) |=>
      !(issue && src_a_en && src_a_fp == $past(dst_fp) && src_a_idx == $past(dst_idx)));

   a_r4_fp_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && dec_kind == 3'd3 && dst_en) |=>
      !(issue && src_a_en && src_a_fp == $past(dst_fp) && src_a_idx == $past(dst_idx)));

   a_r9_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && dec_kind == 3'd4) |=> (!issue || dec_in_slot));

   a_r9_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && dec_kind == 3'd4) |=> (issue || slot_bubble));

   a_r10_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (cycle == $past(cycle) + CYC_W'(1)));
endmodule

bind mc_issue_gate mcig_gate_chk #(.REG_W(REG_W), .CYC_W(CYC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dec_valid   (dec_valid),
   .dec_kind    (dec_kind),
   .dec_in_slot (dec_in_slot),
   .src_a_en    (src_a_en),
   .src_a_fp    (src_a_fp),
   .src_a_idx   (src_a_idx),
   .dst_en      (dst_en),
   .dst_fp      (dst_fp),
   .dst_idx     (dst_idx),
   .issue       (issue),
   .stall       (stall),
   .slot_bubble (slot_bubble),
   .cycle       (cycle)
);

// File: tb/mc_issue_gate_bench.sv
module mc_issue_gate_bench;
   localparam int CLK_PERIOD = 10;
   localparam int REG_W = 5;
   localparam int CYC_W = 16;

   localparam logic [2:0] KI = 3'd0, KL = 3'd1, KS = 3'd2, KF = 3'd3, KB = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dec_valid = 1'b0;
   logic [2:0] dec_kind = '0;
   logic dec_in_slot = 1'b0;
   logic src_a_en = 1'b0, src_a_fp = 1'b0;
   logic [REG_W-1:0] src_a_idx = '0;
   logic src_b_en = 1'b0, src_b_fp = 1'b0;
   logic [REG_W-1:0] src_b_idx = '0;
   logic dst_en = 1'b0, dst_fp = 1'b0;
   logic [REG_W-1:0] dst_idx = '0;
   logic issue, stall, slot_bubble;
   logic [CYC_W-1:0] cycle;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mc_issue_gate #(.REG_W(REG_W), .CYC_W(CYC_W)) u_mc_issue_gate (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
      .dec_in_slot(dec_in_slot), .src_a_en(src_a_en), .src_a_fp(src_a_fp),
      .src_a_idx(src_a_idx), .src_b_en(src_b_en), .src_b_fp(src_b_fp),
      .src_b_idx(src_b_idx), .dst_en(dst_en), .dst_fp(dst_fp), .dst_idx(dst_idx),
      .issue(issue), .stall(stall), .slot_bubble(slot_bubble), .cycle(cycle));

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      dec_valid = 1'b0;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // present one instruction (at a negedge) and wait for it to issue
   task automatic op(input logic [2:0] k, input logic slot,
                     input logic ae, input logic af, input int ai,
                     input logic be, input logic bf, input int bi,
                     input logic de, input logic df, input int di,
                     output int cyc, output int nstall, output int bub0);
      dec_valid = 1'b1; dec_kind = k; dec_in_slot = slot;
      src_a_en = ae; src_a_fp = af; src_a_idx = REG_W'(ai);
      src_b_en = be; src_b_fp = bf; src_b_idx = REG_W'(bi);
      dst_en = de; dst_fp = df; dst_idx = REG_W'(di);
      nstall = 0; cyc = -1;
      #1;
      bub0 = int'(slot_bubble);
      for (int g = 0; g < 40; g++) begin
         if (issue) begin
            cyc = int'(cycle);
            break;
         end
         if (stall !== 1'b1) check("R2 stall while held", int'(stall), 1);
         nstall++;
         @(negedge clk); #1;
      end
      if (cyc < 0) check("R2 instruction never issued", 0, 1);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 cycle after reset", int'(cycle), 0);
      check("R1 issue idle", int'(issue), 0);
      check("R1 stall idle", int'(stall), 0);
      @(negedge clk);
      check("R10 cycle step", int'(cycle), 1);
   endtask

   task automatic t_first_and_stream();
      int c0, c1, c2, s, b;
      op(KI, 0, 1,0,1, 0,0,0, 1,0,5, c0, s, b);
      check("R1 first instr no stall", s, 0);
      op(KI, 0, 1,0,6, 0,0,0, 1,0,7, c1, s, b);
      op(KF, 0, 1,1,1, 0,0,0, 1,1,9, c2, s, b);
      check("R2 back to back 1", c1 - c0, 1);
      check("R2 back to back 2", c2 - c1, 1);
      idle(6);
   endtask

   task automatic t_int_dep();
      int c0, c1, s, b;
      op(KI, 0, 0,0,0, 0,0,0, 1,0,3, c0, s, b);
      op(KI, 0, 1,0,3, 0,0,0, 1,0,4, c1, s, b);
      check("R5 int to int gap", c1 - c0, 1);
      idle(6);
   endtask

   task automatic t_load_dep();
      int c0, c1, s, b;
      op(KL, 0, 1,0,2, 0,0,0, 1,1,4, c0, s, b);
      op(KF, 0, 1,1,4, 1,1,6, 1,1,2, c1, s, b);
      check("R3 load to fp gap", c1 - c0, 2);
      check("R3 load to fp stalls", s, 1);
      idle(6);
   endtask

   task automatic t_fp_dep();
      int c0, c1, s, b;
      op(KF, 0, 1,1,1, 1,1,2, 1,1,3, c0, s, b);
      op(KF, 0, 1,1,5, 1,1,3, 1,1,6, c1, s, b);
      check("R4 fp to fp gap via B", c1 - c0, 4);
      check("R4 fp to fp stalls", s, 3);
      idle(6);
   endtask

   task automatic t_store_data();
      int c0, c1, s, b;
      op(KL, 0, 1,0,2, 0,0,0, 1,1,4, c0, s, b);
      op(KS, 0, 1,0,5, 1,1,4, 0,0,0, c1, s, b);
      check("R6 load to store data gap", c1 - c0, 1);
      idle(6);
      op(KF, 0, 1,1,1, 1,1,2, 1,1,8, c0, s, b);
      op(KS, 0, 1,0,5, 1,1,8, 0,0,0, c1, s, b);
      check("R6 fp to store data gap", c1 - c0, 3);
      idle(6);
      op(KL, 0, 1,0,2, 0,0,0, 1,0,4, c0, s, b);
      op(KS, 0, 1,0,4, 1,1,8, 0,0,0, c1, s, b);
      check("R6 load to store address gap", c1 - c0, 2);
      idle(6);
   endtask

   task automatic t_spaces();
      int c0, c1, s, b;
      op(KF, 0, 0,0,0, 0,0,0, 1,1,3, c0, s, b);
      op(KI, 0, 1,0,3, 0,0,0, 1,0,3, c1, s, b);
      check("R7 fp write int read no dep", c1 - c0, 1);
      idle(6);
   endtask

   task automatic t_idle_countdown();
      int c0, c1, s, b;
      op(KF, 0, 0,0,0, 0,0,0, 1,1,1, c0, s, b);
      idle(2);
      op(KF, 0, 1,1,1, 0,0,0, 1,1,2, c1, s, b);
      check("R8 countdown during idle gap", c1 - c0, 4);
      check("R8 countdown during idle stalls", s, 1);
      idle(6);
   endtask

   task automatic t_branch();
      int c0, c1, s, b;
      op(KB, 0, 1,0,9, 0,0,0, 0,0,0, c0, s, b);
      op(KI, 0, 1,0,10, 0,0,0, 1,0,11, c1, s, b);
      check("R9 bubble flag after branch", b, 1);
      check("R9 non-slot instr waits", c1 - c0, 2);
      idle(3);
      op(KB, 0, 1,0,9, 0,0,0, 0,0,0, c0, s, b);
      op(KI, 1, 1,0,10, 0,0,0, 1,0,11, c1, s, b);
      check("R9 slot instr issues in delay", c1 - c0, 1);
      idle(6);
   endtask

   task automatic t_loop_unsched();
      int c[7];
      int s, b;
      op(KL, 0, 1,0,2, 0,0,0, 1,1,4, c[0], s, b);
      op(KF, 0, 1,1,4, 1,1,6, 1,1,2, c[1], s, b);
      op(KS, 0, 1,0,2, 1,1,2, 0,0,0, c[2], s, b);
      op(KI, 0, 1,0,2, 0,0,0, 1,0,2, c[3], s, b);
      op(KI, 0, 1,0,3, 0,0,0, 1,0,3, c[4], s, b);
      op(KB, 0, 1,0,2, 0,0,0, 0,0,0, c[5], s, b);
      op(KL, 0, 1,0,2, 0,0,0, 1,1,4, c[6], s, b);
      check("R11 unsched fp add", c[1] - c[0], 2);
      check("R11 unsched store", c[2] - c[0], 5);
      check("R11 unsched branch", c[5] - c[0], 8);
      check("R11 unsched iteration", c[6] - c[0], 10);
      idle(6);
   endtask

   task automatic t_loop_sched();
      int c[7];
      int s, b;
      op(KL, 0, 1,0,2, 0,0,0, 1,1,4, c[0], s, b);
      op(KF, 0, 1,1,4, 1,1,6, 1,1,2, c[1], s, b);
      op(KI, 0, 1,0,2, 0,0,0, 1,0,2, c[2], s, b);
      op(KI, 0, 1,0,3, 0,0,0, 1,0,3, c[3], s, b);
      op(KB, 0, 1,0,2, 0,0,0, 0,0,0, c[4], s, b);
      op(KS, 1, 1,0,2, 1,1,2, 0,0,0, c[5], s, b);
      op(KL, 0, 1,0,2, 0,0,0, 1,1,4, c[6], s, b);
      check("R11 sched store in slot", c[5] - c[0], 6);
      check("R11 sched iteration", c[6] - c[0], 7);
      idle(6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_first_and_stream();
      t_int_dep();
      t_load_dep();
      t_fp_dep();
      t_store_data();
      t_spaces();
      t_idle_countdown();
      t_branch();
      t_loop_unsched();
      t_loop_sched();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule